// File: doc/BRIEF.md
# Cache Tag Store with Qualified Match

This block holds one tag word and three status flags for every line of a direct-mapped cache. A cache controller drives the line index and the upper address bits of the current access. The block returns a hit indication in the same cycle, with no clock edge in the path, so the controller can start a data-array access at once. The stored tag and flags can be read out through the same combinational path. Tag and flag writes are registered on the rising clock edge. Each has its own active-low write enable, and each side also has its own active-low output enable.

A mode input decides what the flags mean. In dedicated mode, flag bit 0 is a valid bit, and a line whose valid bit is clear never reports a hit. In generic mode, the three flags are plain user storage and the hit depends only on tag equality. A synchronous active-low clear input wipes every flag of every line in a single edge, which invalidates the whole cache at once. Outputs are modelled as a value plus a drive-enable instead of a tri-state pad.

Top module: `ctag_store`

## Requirements
- R1: The block is selected only when `sel_n` is 0 and `sel` is 1. When it is not selected, `hit_en`, `tag_out_en` and `stat_out_en` are 0, `hit` is 0, and no write takes effect.
- R2: `tag_out_en` is 1 exactly when the block is selected, `tag_oe_n` is 0 and `tag_wr_n` is 1. While it is 1, `tag_out` combinationally shows the tag stored at `addr`.
- R3: `stat_out_en` is 1 exactly when the block is selected and `stat_oe_n` is 0. While it is 1, `stat_out` shows the flags stored at `addr`, with bit 0 = valid, bit 1 = dirty and bit 2 = write-through.
- R4: On a rising edge where the block is selected and `tag_wr_n` is 0, `tag_in` is stored as the tag at `addr`. Flags are not changed by a tag write.
- R5: On a rising edge where the block is selected and `stat_wr_n` is 0, `stat_in` is stored as the flags at `addr`. Tags are not changed by a flag write.
- R6: On a rising edge where `clr_n` is 0, the flags of every line become 0, even if a flag write is requested on the same edge. Stored tags are kept.
- R7: In dedicated mode (`generic_mode` = 0), `hit` is 1 only when `tag_in` equals the stored tag at `addr` and the stored valid bit (flag bit 0) is 1.
- R8: In generic mode (`generic_mode` = 1), `hit` is 1 exactly when `tag_in` equals the stored tag at `addr`, whatever the flags hold.
- R9: `hit` is 0 whenever any of `tag_oe_n`, `tag_wr_n` or `stat_wr_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clears happen on its rising edge |
| clr_n | input | 1 | Synchronous active-low clear of all flags |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| addr | input | $clog2(DEPTH) | Line index |
| generic_mode | input | 1 | 0: flag bit 0 qualifies the hit; 1: flags are user storage |
| tag_wr_n | input | 1 | Active-low tag write enable |
| stat_wr_n | input | 1 | Active-low flag write enable |
| tag_oe_n | input | 1 | Active-low tag output enable |
| stat_oe_n | input | 1 | Active-low flag output enable |
| tag_in | input | TAG_W | Tag to compare or to store |
| stat_in | input | 3 | Flags to store |
| tag_out | output | TAG_W | Stored tag at `addr` (0 when not enabled) |
| tag_out_en | output | 1 | Drive-enable for `tag_out` |
| stat_out | output | 3 | Stored flags at `addr` (0 when not enabled) |
| stat_out_en | output | 1 | Drive-enable for `stat_out` |
| hit | output | 1 | Qualified tag-equality result |
| hit_en | output | 1 | Drive-enable for `hit` |

## Verification
The hardest case to reach from the ports is a dedicated-mode hit. It needs a line whose tag was written earlier, whose valid flag was set afterwards and not wiped by a later clear, and a compare cycle in which all three blocking enables are inactive. Random stimulus on its own seldom lines these up. So the tag input copies the bench's own record of the stored tag on half the cycles, clears are rare, and directed sequences deliberately set, clear and compare a valid flag. A further directed edge asserts the clear and a flag write together and then reads back both the flags and the tags.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
    localparam int STAT_W  = 3;
    localparam int VLD_BIT = 0;
    localparam int DTY_BIT = 1;
    localparam int WT_BIT  = 2;

    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/ctag_outctl.sv
module ctag_outctl (
    input  logic sel_n,
    input  logic sel,
    input  logic tag_wr_n,
    input  logic stat_wr_n,
    input  logic tag_oe_n,
    input  logic stat_oe_n,
    output logic selected,
    output logic tag_we,
    output logic stat_we,
    output logic tag_rd_en,
    output logic stat_rd_en,
    output logic cmp_ok
);
    always_comb begin
        selected   = !sel_n && sel;
        tag_we     = selected && !tag_wr_n;
        stat_we    = selected && !stat_wr_n;
        tag_rd_en  = selected && !tag_oe_n && tag_wr_n;
        stat_rd_en = selected && !stat_oe_n;
        // compare only while the tag bus is idle and no flag write is pending
        cmp_ok     = selected && tag_oe_n && tag_wr_n && stat_wr_n;
    end
endmodule

// File: rtl/ctag_array.sv
module ctag_array
    import ctag_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TAG_W = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [AW-1:0]    addr,
    input  logic             tag_we,
    input  logic             stat_we,
    input  logic [TAG_W-1:0] tag_wdata,
    input  stat_t            stat_wdata,
    output logic [TAG_W-1:0] rd_tag,
    output stat_t            rd_stat
);
    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][STAT_W-1:0] stat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (tag_we && addr == AW'(e))
                st_d.tag[e] = tag_wdata;
            // clear takes priority over a flag write on the same edge
            if (!clr_n)
                st_d.stat[e] = '0;
            else if (stat_we && addr == AW'(e))
                st_d.stat[e] = stat_wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_tag  = st_q.tag[addr];
    assign rd_stat = st_q.stat[addr];

    // R4
    tag_wr_lands_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tag_we |=> (addr != $past(addr)) || (rd_tag == $past(tag_wdata)));

    // R5
    stat_wr_lands_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (stat_we && clr_n) |=> (addr != $past(addr)) || (rd_stat == $past(stat_wdata)));

    // R6
    clr_wipes_chk: assert property (@(posedge clk)
        (!clr_n) |=> (rd_stat == '0));
endmodule

// File: rtl/ctag_compare.sv
module ctag_compare
    import ctag_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [TAG_W-1:0] key,
    input  logic [TAG_W-1:0] stored,
    input  stat_t            flags,
    input  logic             generic_mode,
    input  logic             cmp_ok,
    output logic             hit
);
    logic tag_eq;
    logic qual;

    always_comb begin
        tag_eq = (key == stored);
        qual   = generic_mode || flags[VLD_BIT];
        hit    = cmp_ok && tag_eq && qual;
    end
endmodule

// File: rtl/ctag_store.sv
module ctag_store
    import ctag_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TAG_W = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sel_n,
    input  logic             sel,
    input  logic [AW-1:0]    addr,
    input  logic             generic_mode,
    input  logic             tag_wr_n,
    input  logic             stat_wr_n,
    input  logic             tag_oe_n,
    input  logic             stat_oe_n,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [2:0]       stat_in,
    output logic [TAG_W-1:0] tag_out,
    output logic             tag_out_en,
    output logic [2:0]       stat_out,
    output logic             stat_out_en,
    output logic             hit,
    output logic             hit_en
);
    logic             selected, tag_we, stat_we, tag_rd_en, stat_rd_en, cmp_ok;
    logic [TAG_W-1:0] rd_tag;
    stat_t            rd_stat;

    ctag_outctl u_ctl (
        .sel_n      (sel_n),
        .sel        (sel),
        .tag_wr_n   (tag_wr_n),
        .stat_wr_n  (stat_wr_n),
        .tag_oe_n   (tag_oe_n),
        .stat_oe_n  (stat_oe_n),
        .selected   (selected),
        .tag_we     (tag_we),
        .stat_we    (stat_we),
        .tag_rd_en  (tag_rd_en),
        .stat_rd_en (stat_rd_en),
        .cmp_ok     (cmp_ok)
    );

    ctag_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_arr (
        .clk        (clk),
        .clr_n      (clr_n),
        .addr       (addr),
        .tag_we     (tag_we),
        .stat_we    (stat_we),
        .tag_wdata  (tag_in),
        .stat_wdata (stat_in),
        .rd_tag     (rd_tag),
        .rd_stat    (rd_stat)
    );

    ctag_compare #(.TAG_W(TAG_W)) u_cmp (
        .key          (tag_in),
        .stored       (rd_tag),
        .flags        (rd_stat),
        .generic_mode (generic_mode),
        .cmp_ok       (cmp_ok),
        .hit          (hit)
    );

    assign tag_out     = tag_rd_en  ? rd_tag  : '0;
    assign tag_out_en  = tag_rd_en;
    assign stat_out    = stat_rd_en ? rd_stat : '0;
    assign stat_out_en = stat_rd_en;
    assign hit_en      = selected;

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel_n || !sel) |-> !(hit || hit_en || tag_out_en || stat_out_en));

    // R7
    dedicated_needs_valid_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (hit && !generic_mode) |-> rd_stat[VLD_BIT]);

    // R8
    hit_means_equal_chk: assert property (@(posedge clk) disable iff (!clr_n)
        hit |-> (tag_in == rd_tag));

    // R9
    busy_blocks_hit_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!tag_oe_n || !tag_wr_n || !stat_wr_n) |-> !hit);
endmodule

// File: tb/sim_ctag_store.sv
`timescale 1ns/1ps
module sim_ctag_store;
    localparam int DEPTH = 64;
    localparam int TAG_W = 12;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic clr_n, sel_n, sel, generic_mode;
    logic tag_wr_n, stat_wr_n, tag_oe_n, stat_oe_n;
    logic [AW-1:0]    addr;
    logic [TAG_W-1:0] tag_in;
    logic [2:0]       stat_in;
    logic [TAG_W-1:0] tag_out;
    logic [2:0]       stat_out;
    logic tag_out_en, stat_out_en, hit, hit_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [TAG_W-1:0] m_tag  [DEPTH];
    logic [2:0]       m_stat [DEPTH];

    always #2.5 clk = ~clk;

    ctag_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
        .clk(clk), .clr_n(clr_n), .sel_n(sel_n), .sel(sel), .addr(addr),
        .generic_mode(generic_mode), .tag_wr_n(tag_wr_n), .stat_wr_n(stat_wr_n),
        .tag_oe_n(tag_oe_n), .stat_oe_n(stat_oe_n), .tag_in(tag_in), .stat_in(stat_in),
        .tag_out(tag_out), .tag_out_en(tag_out_en), .stat_out(stat_out),
        .stat_out_en(stat_out_en), .hit(hit), .hit_en(hit_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hit();
        bit s = !sel_n && sel;
        bit ok = s && tag_oe_n && tag_wr_n && stat_wr_n;
        return ok && (tag_in == m_tag[addr]) && (generic_mode || m_stat[addr][0]);
    endfunction

    function automatic string hit_req();
        if (sel_n || !sel) return "R1";
        if (!tag_oe_n || !tag_wr_n || !stat_wr_n) return "R9";
        if (generic_mode) return "R8";
        return "R7";
    endfunction

    // inputs are set; check the combinational outputs, then take one edge
    task automatic step();
        bit s;
        #1;
        s = !sel_n && sel;
        chk("R1", "hit_en", 32'(hit_en), 32'(s));
        chk("R2", "tag_out_en", 32'(tag_out_en), 32'(s && !tag_oe_n && tag_wr_n));
        if (s && !tag_oe_n && tag_wr_n)
            chk("R2", "tag_out", 32'(tag_out), 32'(m_tag[addr]));
        chk("R3", "stat_out_en", 32'(stat_out_en), 32'(s && !stat_oe_n));
        if (s && !stat_oe_n)
            chk("R3", "stat_out", 32'(stat_out), 32'(m_stat[addr]));
        chk(hit_req(), "hit", 32'(hit), 32'(exp_hit()));
        @(posedge clk);
        if (s && !tag_wr_n) m_tag[addr] = tag_in;
        if (!clr_n) begin
            for (int e = 0; e < DEPTH; e++) m_stat[e] = '0;
        end else if (s && !stat_wr_n) begin
            m_stat[addr] = stat_in;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        sel_n = 1'b0; sel = 1'b1; clr_n = 1'b1; generic_mode = 1'b0;
        tag_wr_n = 1'b1; stat_wr_n = 1'b1; tag_oe_n = 1'b1; stat_oe_n = 1'b1;
        tag_in = '0; stat_in = '0; addr = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7);
        for (int e = 0; e < DEPTH; e++) begin m_tag[e] = '0; m_stat[e] = '0; end
        idle();
        sel_n = 1'b1; sel = 1'b0; clr_n = 1'b0;
        @(negedge clk);
        // reset state, deselected: R1 quiet outputs, clear lands (R6)
        step();
        // deselected write attempt has no effect (R1)
        tag_wr_n = 1'b0; stat_wr_n = 1'b0; tag_in = 12'hABC; stat_in = 3'b111; clr_n = 1'b1;
        step();
        idle(); stat_oe_n = 1'b0;
        #1 chk("R1", "stat after deselected write", 32'(stat_out), 32'h0);
        @(negedge clk);

        // fill every line: tags and flags (R4, R5)
        for (int a = 0; a < DEPTH; a++) begin
            idle();
            addr = AW'(a); tag_in = TAG_W'(a * 37 + 5); tag_wr_n = 1'b0;
            stat_wr_n = 1'b0; stat_in = 3'(a);
            step();
        end
        idle(); addr = AW'(9); tag_oe_n = 1'b0; stat_oe_n = 1'b0;
        #1 chk("R4", "tag readback line 9", 32'(tag_out), 32'(9 * 37 + 5));
        chk("R5", "flag readback line 9", 32'(stat_out), 32'h1);
        @(negedge clk);

        // flag-only write leaves the tag (R5)
        idle(); addr = AW'(9); stat_wr_n = 1'b0; stat_in = 3'b110; tag_in = 12'h000;
        step();
        idle(); addr = AW'(9); tag_oe_n = 1'b0;
        #1 chk("R5", "tag kept after flag write", 32'(tag_out), 32'(9 * 37 + 5));
        @(negedge clk);

        // dedicated mode, equal tag but valid clear -> no hit (R7)
        idle(); addr = AW'(9); tag_in = TAG_W'(9 * 37 + 5);
        #1 chk("R7", "equal tag, valid 0", 32'(hit), 32'h0);
        @(negedge clk);
        // generic mode, same line -> hit (R8)
        idle(); generic_mode = 1'b1; addr = AW'(9); tag_in = TAG_W'(9 * 37 + 5);
        #1 chk("R8", "generic equal tag", 32'(hit), 32'h1);
        @(negedge clk);
        // set valid, dedicated hit (R7)
        idle(); addr = AW'(9); stat_wr_n = 1'b0; stat_in = 3'b001;
        step();
        idle(); addr = AW'(9); tag_in = TAG_W'(9 * 37 + 5);
        #1 chk("R7", "equal tag, valid 1", 32'(hit), 32'h1);
        // blocked by pending flag write (R9)
        stat_wr_n = 1'b0; stat_in = 3'b001;
        #1 chk("R9", "hit during flag write", 32'(hit), 32'h0);
        stat_wr_n = 1'b1; tag_oe_n = 1'b0;
        #1 chk("R9", "hit during tag read", 32'(hit), 32'h0);
        @(negedge clk);

        // clear and flag write on the same edge: clear wins, tags stay (R6)
        idle(); addr = AW'(9); clr_n = 1'b0; stat_wr_n = 1'b0; stat_in = 3'b111;
        step();
        idle(); addr = AW'(9); stat_oe_n = 1'b0; tag_oe_n = 1'b0;
        #1 chk("R6", "flags after clear+write", 32'(stat_out), 32'h0);
        chk("R6", "tag kept after clear", 32'(tag_out), 32'(9 * 37 + 5));
        addr = AW'(DEPTH - 1);
        #1 chk("R6", "last line flags cleared", 32'(stat_out), 32'h0);
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            sel_n        = ($urandom % 8) == 0;
            sel          = ($urandom % 8) != 0;
            addr         = AW'($urandom % DEPTH);
            tag_wr_n     = ($urandom % 4) != 0;
            stat_wr_n    = ($urandom % 4) != 0;
            tag_oe_n     = ($urandom % 3) == 0 ? 1'b0 : 1'b1;
            stat_oe_n    = 1'($urandom % 2);
            clr_n        = ($urandom % 60) != 0;
            generic_mode = 1'($urandom % 2);
            tag_in       = ($urandom % 2) != 0 ? m_tag[addr] : TAG_W'($urandom);
            stat_in      = 3'($urandom);
            step();
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule